// File: doc/BRIEF.md
# Byte-Lane Switching-Noise Pattern Tester

This block fills a region of a word-addressed memory with a data pattern meant to provoke simultaneous switching noise inside each byte lane, then reads the region back and checks it. Every written word carries one byte value repeated in all lanes. The word that follows it is its exact bitwise inverse, so every data wire toggles between the two writes of a pair. The byte value advances by one per pair and cycles through all 256 values.

A controller presents a base address and a length in words, then pulses `start`. The tester first writes the whole region on consecutive cycles. It then runs a separate read pass that rebuilds the expected sequence from the start of the region. The read pass stops at the first word that differs. At that point `done` rises, `pass` reports the outcome, and the failing address, the expected word and the observed word are held until the next start.

Top module: `lane_ssn_tester`

## Requirements
- R1: After reset, `done`, `pass` and `mem_req` are 0, and `fail_addr`, `fail_exp` and `fail_act` are 0.
- R2: The word at offset i from the base is built from the byte value b = (i div 2) mod 256. An even offset holds b in all four byte lanes. An odd offset holds the bitwise inverse of that word.
- R3: Offsets 0 and 1 hold 0x00000000 and 0xFFFFFFFF. Offsets 2 and 3 hold 0x01010101 and 0xFEFEFEFE. Offsets 510 and 511 hold 0xFFFFFFFF and 0x00000000.
- R4: For regions longer than 512 words the byte value wraps to 0x00, so offset 512 holds 0x00000000 and offset 514 holds 0x01010101.
- R5: A run writes exactly `len_words` words to addresses base to base+len-1, in rising order on consecutive cycles. It then reads the same addresses in the same order. No read is issued before the last write. Read data is taken one cycle after the read request.
- R6: When every word read back matches, `done` and `pass` go to 1, and the three fail fields read 0.
- R7: At the first mismatch, `done` goes to 1 and `pass` goes to 0. `fail_addr`, `fail_exp` and `fail_act` hold the address, the expected word and the observed word. No more than one further read follows the failing read, and no writes follow.
- R8: A start with `len_words` = 0 causes no memory access. It raises `done` and `pass` on the same clock edge that samples the start.
- R9: A `start` pulse during a run is ignored, including any new base or length presented with it.
- R10: `done` and the result fields hold until the next accepted start. That start clears `done` on the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a run (accepted only when idle) |
| base_addr | input | ADDR_W | First word address of the region |
| len_words | input | LEN_W | Region length in words |
| mem_req | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| done | output | 1 | Run finished (held) |
| pass | output | 1 | Run finished with no mismatch |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_exp | output | DATA_W | Expected word at that address |
| fail_act | output | DATA_W | Word actually read there |

## Verification
Two events can fall on the same cycle: the compare of the final word, which normally ends the run with a pass, and the detection of a mismatch. The bench provokes this by corrupting only the last word of a region as the memory model stores it. The result is judged correct only if `pass` is 0 and the fail fields name that last address, with its expected word and its corrupted value. A second overlap is a `start` arriving while a run is busy. The bench judges it by the number of accesses and the addresses the run actually performs.

// File: rtl/ssn_pkg.sv
package ssn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_DRAIN = 2'd3
  } ssn_state_e;

  localparam int unsigned LANE_W   = 8;
  localparam int unsigned PAT_IDX_W = LANE_W + 1;
endpackage

// File: rtl/ssn_pattern_gen.sv
module ssn_pattern_gen
  import ssn_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [PAT_IDX_W-1:0] idx,
  output logic [DATA_W-1:0]    word
);
  localparam int unsigned LANES = DATA_W / LANE_W;

  logic [LANE_W-1:0] lane_val;

  // byte value advances once per pair; odd slot inverts every lane
  always_comb begin
    lane_val = idx[PAT_IDX_W-1:1] ^ {LANE_W{idx[0]}};
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word[g*LANE_W +: LANE_W] = lane_val;
  end

  // R2: all lanes carry one value
  always_comb begin
    if (!$isunknown(idx)) begin
      for (int k = 1; k < LANES; k++) begin
        p_lanes_equal_r2: assert (word[k*LANE_W +: LANE_W] == word[LANE_W-1:0]);
      end
    end
  end
endmodule

// File: rtl/ssn_seq_ctrl.sv
module ssn_seq_ctrl
  import ssn_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    base_in,
  input  logic [LEN_W-1:0]     len_in,
  input  logic                 mismatch,
  output logic                 wr_en,
  output logic                 rd_en,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [PAT_IDX_W-1:0] pat_idx,
  output logic                 start_acc,
  output logic                 zero_len,
  output logic                 cmp_vld,
  output logic                 cmp_last,
  output logic [ADDR_W-1:0]    cmp_addr,
  output logic [PAT_IDX_W-1:0] cmp_idx
);
  ssn_state_e state_q, state_d;
  logic [LEN_W-1:0]     idx_q, idx_d;
  logic [ADDR_W-1:0]    base_q;
  logic [LEN_W-1:0]     len_q;
  logic                 ld_en;
  logic                 last_idx;
  logic                 cmp_vld_q, cmp_vld_d;
  logic                 cmp_last_q;
  logic [ADDR_W-1:0]    cmp_addr_q;
  logic [PAT_IDX_W-1:0] cmp_idx_q;

  assign start_acc = (state_q == ST_IDLE) && start;
  assign zero_len  = start_acc && (len_in == '0);
  assign last_idx  = (idx_q == len_q - 1'b1);
  assign wr_en     = (state_q == ST_WRITE);
  assign rd_en     = (state_q == ST_READ);
  assign addr_o    = base_q + ADDR_W'(idx_q);
  assign pat_idx   = idx_q[PAT_IDX_W-1:0];

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    ld_en     = 1'b0;
    cmp_vld_d = rd_en && !mismatch;
    unique case (state_q)
      ST_IDLE: begin
        if (start_acc && !zero_len) begin
          state_d = ST_WRITE;
          idx_d   = '0;
          ld_en   = 1'b1;
        end
      end
      ST_WRITE: begin
        if (last_idx) begin
          state_d = ST_READ;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_READ: begin
        idx_d = idx_q + 1'b1;
        if (mismatch)      state_d = ST_IDLE;
        else if (last_idx) state_d = ST_DRAIN;
      end
      ST_DRAIN: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      base_q     <= '0;
      len_q      <= '0;
      cmp_vld_q  <= 1'b0;
      cmp_last_q <= 1'b0;
      cmp_addr_q <= '0;
      cmp_idx_q  <= '0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      cmp_vld_q <= cmp_vld_d;
      if (ld_en) begin
        base_q <= base_in;
        len_q  <= len_in;
      end
      if (rd_en) begin
        cmp_last_q <= last_idx;
        cmp_addr_q <= addr_o;
        cmp_idx_q  <= idx_q[PAT_IDX_W-1:0];
      end
    end
  end

  assign cmp_vld  = cmp_vld_q;
  assign cmp_last = cmp_last_q;
  assign cmp_addr = cmp_addr_q;
  assign cmp_idx  = cmp_idx_q;

  // R9: a run keeps its region regardless of start
  p_region_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(base_q) && $stable(len_q)));

  // R5: the read pass follows the write pass without a gap
  p_write_to_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && last_idx) |=> (rd_en && addr_o == base_q));
endmodule

// File: rtl/ssn_verdict.sv
module ssn_verdict #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_acc,
  input  logic              zero_len,
  input  logic              cmp_vld,
  input  logic              cmp_last,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [DATA_W-1:0] exp_word,
  input  logic [DATA_W-1:0] rdata,
  output logic              mismatch,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_act
);
  logic              done_q, done_d;
  logic              pass_q, pass_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d;
  logic [DATA_W-1:0] fexp_q, fexp_d;
  logic [DATA_W-1:0] fact_q, fact_d;

  assign mismatch = cmp_vld && (rdata != exp_word);

  always_comb begin
    done_d  = done_q;
    pass_d  = pass_q;
    faddr_d = faddr_q;
    fexp_d  = fexp_q;
    fact_d  = fact_q;
    if (start_acc) begin
      done_d  = zero_len;
      pass_d  = zero_len;
      faddr_d = '0;
      fexp_d  = '0;
      fact_d  = '0;
    end else if (mismatch) begin
      done_d  = 1'b1;
      pass_d  = 1'b0;
      faddr_d = cmp_addr;
      fexp_d  = exp_word;
      fact_d  = rdata;
    end else if (cmp_vld && cmp_last) begin
      done_d = 1'b1;
      pass_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      faddr_q <= '0;
      fexp_q  <= '0;
      fact_q  <= '0;
    end else begin
      done_q  <= done_d;
      pass_q  <= pass_d;
      faddr_q <= faddr_d;
      fexp_q  <= fexp_d;
      fact_q  <= fact_d;
    end
  end

  assign done      = done_q;
  assign pass      = pass_q;
  assign fail_addr = faddr_q;
  assign fail_exp  = fexp_q;
  assign fail_act  = fact_q;

  // R6: pass is only ever reported together with done
  p_pass_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |-> done_q);

  // R7: a failure report is frozen until the next start
  p_fail_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !pass_q && !start_acc) |=>
      (!pass_q && $stable(faddr_q) && $stable(fexp_q) && $stable(fact_q)));

  // R10: done holds until an accepted start
  p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_acc) |=> done_q);
endmodule

// File: rtl/lane_ssn_tester.sv
module lane_ssn_tester
  import ssn_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  len_words,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_act
);
  logic                 rst_meta_q, rst_sync_q;
  logic                 wr_en, rd_en;
  logic [PAT_IDX_W-1:0] pat_idx, cmp_idx;
  logic                 start_acc, zero_len;
  logic                 cmp_vld, cmp_last;
  logic [ADDR_W-1:0]    cmp_addr;
  logic [DATA_W-1:0]    exp_word;
  logic                 mismatch;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ssn_seq_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start     (start),
    .base_in   (base_addr),
    .len_in    (len_words),
    .mismatch  (mismatch),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr_o    (mem_addr),
    .pat_idx   (pat_idx),
    .start_acc (start_acc),
    .zero_len  (zero_len),
    .cmp_vld   (cmp_vld),
    .cmp_last  (cmp_last),
    .cmp_addr  (cmp_addr),
    .cmp_idx   (cmp_idx)
  );

  ssn_pattern_gen #(.DATA_W(DATA_W)) u_wr_pat (
    .idx  (pat_idx),
    .word (mem_wdata)
  );

  ssn_pattern_gen #(.DATA_W(DATA_W)) u_exp_pat (
    .idx  (cmp_idx),
    .word (exp_word)
  );

  ssn_verdict #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_verdict (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start_acc (start_acc),
    .zero_len  (zero_len),
    .cmp_vld   (cmp_vld),
    .cmp_last  (cmp_last),
    .cmp_addr  (cmp_addr),
    .exp_word  (exp_word),
    .rdata     (mem_rdata),
    .mismatch  (mismatch),
    .done      (done),
    .pass      (pass),
    .fail_addr (fail_addr),
    .fail_exp  (fail_exp),
    .fail_act  (fail_act)
  );

  assign mem_req = wr_en || rd_en;
  assign mem_we  = wr_en;

  // R5: each phase walks the region one word per cycle
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (mem_req && $past(mem_req) && (mem_we == $past(mem_we))) |->
      (mem_addr == $past(mem_addr) + 1'b1));

  // R2: each odd write is the inverse of the write before it
  p_pair_inverse_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (wr_en && $past(wr_en) && pat_idx[0]) |-> (mem_wdata == ~$past(mem_wdata)));

  // R8: an empty region finishes at once without touching memory
  p_zero_quiet_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    zero_len |=> (!mem_req && done && pass));
endmodule

// File: tb/sim_lane_ssn_tester.sv
module sim_lane_ssn_tester;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] base_addr = '0;
  logic [15:0] len_words = '0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        done, pass;
  logic [15:0] fail_addr;
  logic [31:0] fail_exp, fail_act;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #10 clk = ~clk;

  lane_ssn_tester u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .len_words(len_words), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .pass(pass), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_act(fail_act)
  );

  // memory model with optional stuck-bit injection on store
  logic [31:0] mem [0:1023];
  logic        inj_en = 1'b0;
  logic [15:0] inj_addr = '0;
  logic [31:0] inj_mask = '0;

  always @(posedge clk) begin
    if (mem_req && mem_we)
      mem[mem_addr[9:0]] <= (inj_en && mem_addr == inj_addr) ? (mem_wdata ^ inj_mask) : mem_wdata;
    if (mem_req && !mem_we)
      mem_rdata <= mem[mem_addr[9:0]];
  end

  function automatic logic [31:0] exp_word(input int i);
    logic [7:0] b;
    b = 8'(i / 2);
    return {4{b}} ^ {32{i[0]}};
  endfunction

  // access monitor
  logic        mon_clr = 1'b0;
  int          mon_base = 0;
  int          mon_len  = 0;
  int          wr_cnt, rd_cnt, ord_err;

  always @(posedge clk) begin
    if (mon_clr) begin
      wr_cnt = 0; rd_cnt = 0; ord_err = 0;
    end else if (mem_req) begin
      if (mem_we) begin
        if (mem_addr != 16'(mon_base + wr_cnt) || mem_wdata != exp_word(wr_cnt)) ord_err++;
        wr_cnt++;
      end else begin
        if (mem_addr != 16'(mon_base + rd_cnt) || wr_cnt != mon_len) ord_err++;
        rd_cnt++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=0x%08h exp=0x%08h", tag, act, expv);
    end
  endtask

  task automatic launch(input int b, input int l);
    @(negedge clk);
    base_addr = 16'(b); len_words = 16'(l);
    mon_base = b; mon_len = l; mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int w;
    w = 0;
    while (!done && w < 5000) begin
      @(negedge clk);
      w++;
    end
    chk(done, {tag, " done reached"}, 32'(done), 32'd1);
  endtask

  task automatic t_reset;
    chk(!done && !pass && !mem_req, "R1 idle outputs", {29'd0, done, pass, mem_req}, 32'd0);
    chk(fail_addr == 0 && fail_exp == 0 && fail_act == 0, "R1 fail fields", fail_exp, 32'd0);
  endtask

  task automatic t_short;
    launch(5, 7);
    chk(!done, "R10 done cleared by start", 32'(done), 32'd0);
    wait_done("R6");
    chk(pass, "R6 pass", 32'(pass), 32'd1);
    chk(fail_addr == 0 && fail_act == 0, "R6 fail fields zero", fail_act, 32'd0);
    chk(wr_cnt == 7 && rd_cnt == 7, "R5 access counts", 32'(wr_cnt * 256 + rd_cnt), 32'(7 * 256 + 7));
    chk(ord_err == 0, "R5 order and R2 data", 32'(ord_err), 32'd0);
    for (int i = 0; i < 7; i++)
      chk(mem[5 + i] == exp_word(i), "R2 stored word", mem[5 + i], exp_word(i));
  endtask

  task automatic t_full;
    launch(16'h40, 512);
    wait_done("R3");
    chk(pass && ord_err == 0, "R3 full cycle pass", 32'(ord_err), 32'd0);
    chk(mem[16'h40] == 32'h0000_0000, "R3 offset 0", mem[16'h40], 32'h0000_0000);
    chk(mem[16'h41] == 32'hFFFF_FFFF, "R3 offset 1", mem[16'h41], 32'hFFFF_FFFF);
    chk(mem[16'h42] == 32'h0101_0101, "R3 offset 2", mem[16'h42], 32'h0101_0101);
    chk(mem[16'h43] == 32'hFEFE_FEFE, "R3 offset 3", mem[16'h43], 32'hFEFE_FEFE);
    chk(mem[16'h40 + 510] == 32'hFFFF_FFFF, "R3 offset 510", mem[16'h40 + 510], 32'hFFFF_FFFF);
    chk(mem[16'h40 + 511] == 32'h0000_0000, "R3 offset 511", mem[16'h40 + 511], 32'h0000_0000);
  endtask

  task automatic t_wrap;
    launch(16'h100, 600);
    wait_done("R4");
    chk(pass && wr_cnt == 600 && rd_cnt == 600, "R4 long run", 32'(rd_cnt), 32'd600);
    chk(mem[16'h100 + 512] == 32'h0000_0000, "R4 offset 512", mem[16'h100 + 512], 32'h0000_0000);
    chk(mem[16'h100 + 513] == 32'hFFFF_FFFF, "R4 offset 513", mem[16'h100 + 513], 32'hFFFF_FFFF);
    chk(mem[16'h100 + 514] == 32'h0101_0101, "R4 offset 514", mem[16'h100 + 514], 32'h0101_0101);
  endtask

  task automatic t_zero;
    launch(16'h300, 0);
    chk(done && pass, "R8 immediate done pass", {30'd0, done, pass}, 32'd3);
    repeat (3) @(negedge clk);
    chk(wr_cnt == 0 && rd_cnt == 0, "R8 no access", 32'(wr_cnt + rd_cnt), 32'd0);
  endtask

  task automatic t_fail_mid;
    inj_en = 1'b1; inj_addr = 16'd203; inj_mask = 32'h0000_0200;
    launch(200, 16);
    wait_done("R7 mid");
    inj_en = 1'b0;
    chk(!pass, "R7 pass low", 32'(pass), 32'd0);
    chk(fail_addr == 16'd203, "R7 fail addr", 32'(fail_addr), 32'd203);
    chk(fail_exp == 32'hFEFE_FEFE, "R7 fail exp", fail_exp, 32'hFEFE_FEFE);
    chk(fail_act == 32'hFEFE_FCFE, "R7 fail act", fail_act, 32'hFEFE_FCFE);
    chk(rd_cnt <= 5 && wr_cnt == 16, "R7 early stop", 32'(rd_cnt), 32'd5);
    repeat (4) @(negedge clk);
    chk(done && !pass && fail_addr == 16'd203, "R7 result held", 32'(fail_addr), 32'd203);
  endtask

  task automatic t_fail_last;
    inj_en = 1'b1; inj_addr = 16'd107; inj_mask = 32'h0000_0001;
    launch(100, 8);
    wait_done("R7 last");
    inj_en = 1'b0;
    chk(!pass, "R7 last-word pass low", 32'(pass), 32'd0);
    chk(fail_addr == 16'd107, "R7 last-word addr", 32'(fail_addr), 32'd107);
    chk(fail_exp == 32'hFCFC_FCFC, "R7 last-word exp", fail_exp, 32'hFCFC_FCFC);
    chk(fail_act == 32'hFCFC_FCFD, "R7 last-word act", fail_act, 32'hFCFC_FCFD);
  endtask

  task automatic t_busy_start;
    launch(16'h200, 20);
    repeat (5) @(negedge clk);
    base_addr = 16'h0; len_words = 16'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (22) @(negedge clk);
    base_addr = 16'h0; len_words = 16'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R9");
    chk(pass && wr_cnt == 20 && rd_cnt == 20 && ord_err == 0, "R9 start ignored while busy",
        32'(rd_cnt), 32'd20);
  endtask

  task automatic t_restart;
    inj_en = 1'b1; inj_addr = 16'd50; inj_mask = 32'h8000_0000;
    launch(50, 4);
    wait_done("R10 pre");
    inj_en = 1'b0;
    chk(!pass && fail_addr == 16'd50, "R10 failed run", 32'(fail_addr), 32'd50);
    launch(50, 4);
    chk(!done && !pass && fail_act == 0, "R10 cleared on restart", {30'd0, done, pass}, 32'd0);
    wait_done("R10 post");
    chk(pass, "R10 clean rerun passes", 32'(pass), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_short;
    t_full;
    t_wrap;
    t_zero;
    t_fail_mid;
    t_fail_last;
    t_busy_start;
    t_restart;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule